// File: doc/BRIEF.md
# Five-Level Leg Output Mismatch Detector

This block watches one leg of a single-phase five-level inverter for a terminal voltage that does not match the gate pattern being driven. Every clock it takes a sampled DC link voltage, a sampled terminal voltage and the 8-bit gate word. It snaps the terminal sample to the nearest of five levels, and it reads the level that the gate word should produce. Both level codes are reported on the block's outputs.

Disagreement between the two codes is expected for short periods around switching edges. Device drops and sensor offsets are also present. The quantizer absorbs small errors, and a saturating run-length counter absorbs short disagreements. A fault is flagged only when the disagreement lasts longer than a cycle limit set by a parameter. The fault flag is sticky and is released by a synchronous clear. Gate words that are not one of the nine legal patterns are flagged, and they neither advance nor reset the run.

Top module: `level_mismatch_detector`

## Requirements
- R1: While `rstN` is low at a clock edge, the block sets `quantLevel` and `expLevel` to 2, and `badPattern` and `faultFlag` to 0.
- R2: The level code is 0 for -Vdc, 1 for -Vdc/2, 2 for 0, 3 for +Vdc/2 and 4 for +Vdc. The levels are computed from `dcLink`. `quantLevel` is the code of the level nearest to `vTerm`.
- R3: A `vTerm` sample that lies exactly halfway between two levels takes the code of the level closer to zero.
- R4: `expLevel` decodes the gate word, which holds switches S11..S24 with S11 at bit 7. 0xC3 gives 4. 0xC6 and 0x63 give 3. 0xCC, 0x66 and 0x33 give 2. 0x6C and 0x36 give 1. 0x3C gives 0.
- R5: Any other gate word sets `badPattern` to 1 and `expLevel` to 2. Every legal word sets `badPattern` to 0.
- R6: `faultFlag` rises only after a disagreement between the registered codes has lasted LIMIT+1 consecutive registered cycles. A shorter run leaves it low.
- R7: One registered cycle in which the codes agree, with a legal pattern, restarts the run from zero.
- R8: Registered cycles with `badPattern` high neither extend nor restart the run.
- R9: `faultFlag` stays high until `clearFault` is sampled high. The clear wins over a fault being set in the same cycle.
- R10: `quantLevel`, `expLevel` and `badPattern` reflect the inputs sampled at the previous clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clearFault | input | 1 | Synchronous release of the sticky fault flag |
| dcLink | input | DATA_W | Signed DC link sample, expected to be non-negative |
| vTerm | input | DATA_W | Signed terminal voltage sample, same scale as `dcLink` |
| gateWord | input | 8 | Applied gate pattern, S11 in bit 7 down to S24 in bit 0 |
| quantLevel | output | 3 | Registered nearest-level code of `vTerm` |
| expLevel | output | 3 | Registered level code implied by `gateWord` |
| badPattern | output | 1 | Registered flag for a gate word that is not legal |
| faultFlag | output | 1 | Sticky persistent-mismatch fault |

## Verification
Two situations are hardest to reach from the ports: a mismatch run that is interrupted by illegal gate words, and a run that ends exactly one cycle short of the limit. The stimulus reaches them through directed segments. It holds a fixed gate word against a terminal sample at a different level for a counted number of cycles, sometimes with a burst of illegal words inside the run, and then checks the fault flag on the cycles on either side of the threshold. Halfway samples are driven at both positive and negative midpoints. Long randomized segments with varying DC link values and noise are then compared against a behavioural model on every clock.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  typedef enum logic [2:0] {
    LVL_NEG_FULL = 3'd0,
    LVL_NEG_HALF = 3'd1,
    LVL_ZERO     = 3'd2,
    LVL_POS_HALF = 3'd3,
    LVL_POS_FULL = 3'd4
  } level_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic mismatch;
    logic invalid;
    logic atLimit;
  } dp_status_t;

endpackage

// File: rtl/mmd_datapath.sv
module mmd_datapath
  import mmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LIMIT  = 5000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] dcLink,
  input  logic signed [DATA_W-1:0] vTerm,
  input  logic [7:0]               gateWord,
  input  ctrl_strobe_t             strobe,
  output dp_status_t               status,
  output logic [2:0]               quantLevel,
  output logic [2:0]               expLevel,
  output logic                     badPattern
);

  localparam int EXT_W = DATA_W + 3;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam int N_THR = 4;

  logic signed [EXT_W-1:0] dcExt, dcX3, vX4;
  logic signed [EXT_W-1:0] thr [N_THR];
  logic [N_THR-1:0]        above;
  logic [2:0]              quantNext;
  level_e                  expNext;
  logic                    badNext;
  logic [CNT_W-1:0]        runCnt;

  // scale so that midpoints +-Vdc/4 and +-3Vdc/4 become integers
  always_comb begin
    dcExt  = {{3{dcLink[DATA_W-1]}}, dcLink};
    dcX3   = (dcExt <<< 1) + dcExt;
    vX4    = {vTerm[DATA_W-1], vTerm, 2'b00};
    thr[0] = -dcX3;
    thr[1] = -dcExt;
    thr[2] = dcExt;
    thr[3] = dcX3;
  end

  // thermometer of midpoint crossings; ties fall toward zero
  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    if (i < N_THR / 2) begin : g_neg
      assign above[i] = (vX4 >= thr[i]);
    end else begin : g_pos
      assign above[i] = (vX4 > thr[i]);
    end
  end

  always_comb begin
    quantNext = 3'd0;
    for (int k = 0; k < N_THR; k++) quantNext = quantNext + 3'(above[k]);
  end

  always_comb begin
    badNext = 1'b0;
    case (gateWord)
      8'hC3:               expNext = LVL_POS_FULL;
      8'hC6, 8'h63:        expNext = LVL_POS_HALF;
      8'hCC, 8'h66, 8'h33: expNext = LVL_ZERO;
      8'h6C, 8'h36:        expNext = LVL_NEG_HALF;
      8'h3C:               expNext = LVL_NEG_FULL;
      default: begin
        expNext = LVL_ZERO;
        badNext = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quantLevel <= 3'(LVL_ZERO);
      expLevel   <= 3'(LVL_ZERO);
      badPattern <= 1'b0;
    end else begin
      quantLevel <= quantNext;
      expLevel   <= 3'(expNext);
      badPattern <= badNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                      runCnt <= '0;
    else if (strobe.cntClr)                         runCnt <= '0;
    else if (strobe.cntInc && runCnt != CNT_W'(LIMIT)) runCnt <= runCnt + 1'b1;
  end

  assign status.mismatch = (quantLevel != expLevel);
  assign status.invalid  = badPattern;
  assign status.atLimit  = (runCnt == CNT_W'(LIMIT));

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CNT_W'(LIMIT)); // R6
  AST_MATCH_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!badPattern && quantLevel == expLevel) |=> runCnt == '0); // R7
  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    badPattern |=> $stable(runCnt)); // R8
  AST_INVALID_EXP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    badPattern |-> expLevel == 3'(LVL_ZERO)); // R5
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    quantLevel <= 3'd4 && expLevel <= 3'd4); // R2

endmodule

// File: rtl/mmd_control.sv
module mmd_control
  import mmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearFault,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         faultFlag
);

  always_comb begin
    strobe.cntClr = !status.invalid && !status.mismatch;
    strobe.cntInc = !status.invalid &&  status.mismatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              faultFlag <= 1'b0;
    else if (clearFault)                    faultFlag <= 1'b0;
    else if (strobe.cntInc && status.atLimit) faultFlag <= 1'b1;
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !clearFault) |=> faultFlag); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clearFault |=> !faultFlag); // R9
  AST_FAULT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!faultFlag && !status.atLimit) |=> !faultFlag); // R6

endmodule

// File: rtl/level_mismatch_detector.sv
module level_mismatch_detector
  import mmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LIMIT  = 5000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clearFault,
  input  logic signed [DATA_W-1:0] dcLink,
  input  logic signed [DATA_W-1:0] vTerm,
  input  logic [7:0]               gateWord,
  output logic [2:0]               quantLevel,
  output logic [2:0]               expLevel,
  output logic                     badPattern,
  output logic                     faultFlag
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  mmd_datapath #(.DATA_W(DATA_W), .LIMIT(LIMIT)) dp_i (
    .clk(clk), .rstN(rstN), .dcLink(dcLink), .vTerm(vTerm),
    .gateWord(gateWord), .strobe(strobe), .status(status),
    .quantLevel(quantLevel), .expLevel(expLevel), .badPattern(badPattern)
  );

  mmd_control ctl_i (
    .clk(clk), .rstN(rstN), .clearFault(clearFault),
    .status(status), .strobe(strobe), .faultFlag(faultFlag)
  );

endmodule

// File: tb/level_mismatch_detector_tb_top.sv
module level_mismatch_detector_tb_top;

  localparam int DATA_W = 16;
  localparam int LIMIT  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearFault = 1'b0;
  logic signed [DATA_W-1:0] dcLink = '0;
  logic signed [DATA_W-1:0] vTerm = '0;
  logic [7:0] gateWord = 8'hCC;
  logic [2:0] quantLevel, expLevel;
  logic badPattern, faultFlag;

  always #2ns clk = ~clk; // 250 MHz

  level_mismatch_detector #(.DATA_W(DATA_W), .LIMIT(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .clearFault(clearFault), .dcLink(dcLink),
    .vTerm(vTerm), .gateWord(gateWord), .quantLevel(quantLevel),
    .expLevel(expLevel), .badPattern(badPattern), .faultFlag(faultFlag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mQ = 2, mE = 2, mCnt = 0;
  bit mBad = 0, mFault = 0;

  function automatic int nearestCode(int dc, int v);
    int ks[4] = '{1, -1, 2, -2};
    int best = 0;
    int bestD = (2 * v < 0) ? -2 * v : 2 * v;
    foreach (ks[j]) begin
      int d = 2 * v - ks[j] * dc;
      if (d < 0) d = -d;
      if (d < bestD) begin bestD = d; best = ks[j]; end
    end
    return best + 2;
  endfunction

  function automatic int gateCode(logic [7:0] g);
    case (g)
      8'hC3: return 4;
      8'hC6, 8'h63: return 3;
      8'hCC, 8'h66, 8'h33: return 2;
      8'h6C, 8'h36: return 1;
      8'h3C: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic check(int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(int dc, int v, logic [7:0] g, bit clr);
    dcLink = DATA_W'(dc);
    vTerm = DATA_W'(v);
    gateWord = g;
    clearFault = clr;
    @(posedge clk);
    if (!rstN) begin
      mQ = 2; mE = 2; mBad = 0; mCnt = 0; mFault = 0;
    end else begin
      if (clr) mFault = 0;
      else if (!mBad && mQ != mE && mCnt == LIMIT) mFault = 1;
      if (!mBad) begin
        if (mQ != mE) begin if (mCnt < LIMIT) mCnt++; end
        else mCnt = 0;
      end
      mQ = nearestCode(dc, v);
      mE = gateCode(g);
      mBad = (mE < 0);
      if (mBad) mE = 2;
    end
    @(negedge clk);
    check(quantLevel, mQ, "R2 quantLevel model");
    check(expLevel, mE, "R4 expLevel model");
    check(badPattern, mBad, "R5 badPattern model");
    check(faultFlag, mFault, "R6 faultFlag model");
  endtask

  initial begin
    int dc = 1000;
    int segLen, segLvl, segV;
    logic [7:0] segG;
    logic [7:0] legal[9] = '{8'hC3, 8'hC6, 8'h63, 8'hCC, 8'h66, 8'h33, 8'h6C, 8'h36, 8'h3C};
    @(negedge clk);
    rstN = 0;
    cycle(dc, 1000, 8'hC3, 0);
    cycle(dc, 1000, 8'hFF, 0);
    // R1: reset values
    check(quantLevel, 2, "R1 quantLevel reset");
    check(expLevel, 2, "R1 expLevel reset");
    check(badPattern, 0, "R1 badPattern reset");
    check(faultFlag, 0, "R1 faultFlag reset");
    rstN = 1;
    // R10: first sampled inputs show up after one edge
    cycle(dc, 1000, 8'hC3, 0);
    check(quantLevel, 4, "R10 quant latency");
    check(expLevel, 4, "R10 exp latency");
    // R2 levels and R3 midpoints, against a zero gate word
    cycle(dc, 600, 8'hCC, 0);  check(quantLevel, 3, "R2 +Vdc/2");
    cycle(dc, -480, 8'hCC, 0); check(quantLevel, 1, "R2 -Vdc/2");
    cycle(dc, -1100, 8'hCC, 0); check(quantLevel, 0, "R2 -Vdc");
    cycle(dc, 750, 8'hCC, 0);  check(quantLevel, 3, "R3 +3/4 tie");
    cycle(dc, 250, 8'hCC, 0);  check(quantLevel, 2, "R3 +1/4 tie");
    cycle(dc, -250, 8'hCC, 0); check(quantLevel, 2, "R3 -1/4 tie");
    cycle(dc, -750, 8'hCC, 0); check(quantLevel, 1, "R3 -3/4 tie");
    cycle(dc, -751, 8'hCC, 0); check(quantLevel, 0, "R3 past -3/4");
    // R4 decode of every legal word
    foreach (legal[j]) begin
      cycle(dc, 0, legal[j], 0);
      check(expLevel, gateCode(legal[j]), "R4 decode");
    end
    // R5 illegal word
    cycle(dc, 0, 8'h00, 0);
    check(badPattern, 1, "R5 bad flag");
    check(expLevel, 2, "R5 bad exp");
    // R6 threshold: restart with matches, then hold a mismatch
    cycle(dc, 0, 8'hCC, 1);
    cycle(dc, 0, 8'hCC, 0);
    for (int n = 0; n < LIMIT + 1; n++) cycle(dc, 1000, 8'hCC, 0);
    check(faultFlag, 0, "R6 one short of limit");
    cycle(dc, 1000, 8'hCC, 0);
    check(faultFlag, 1, "R6 at limit");
    // R9 sticky through matches, then cleared
    for (int n = 0; n < 3; n++) cycle(dc, 0, 8'hCC, 0);
    check(faultFlag, 1, "R9 sticky");
    cycle(dc, 0, 8'hCC, 1);
    check(faultFlag, 0, "R9 cleared");
    // R7 one matching cycle restarts the run
    for (int n = 0; n < LIMIT; n++) cycle(dc, 1000, 8'hCC, 0);
    cycle(dc, 0, 8'hCC, 0);
    for (int n = 0; n < LIMIT; n++) cycle(dc, 1000, 8'hCC, 0);
    check(faultFlag, 0, "R7 run restarted");
    // R8 illegal words inside a run
    cycle(dc, 0, 8'hCC, 0);
    cycle(dc, 0, 8'hCC, 0);
    for (int n = 0; n < 4; n++) cycle(dc, 1000, 8'hCC, 0);
    for (int n = 0; n < 3; n++) cycle(dc, 1000, 8'hFF, 0);
    cycle(dc, 1000, 8'hCC, 0);
    cycle(dc, 1000, 8'hCC, 0);
    check(faultFlag, 0, "R8 hold not advanced");
    cycle(dc, 1000, 8'hCC, 0);
    check(faultFlag, 1, "R8 hold not restarted");
    // R9 clear wins while mismatch continues at limit
    cycle(dc, 1000, 8'hCC, 1);
    check(faultFlag, 0, "R9 clear priority");
    cycle(dc, 1000, 8'hCC, 0);
    check(faultFlag, 1, "R9 refault");
    // randomized segments compared against the model every clock
    for (int s = 0; s < 600; s++) begin
      dc = 200 + int'($urandom_range(7800));
      segLen = 1 + int'($urandom_range(9));
      segLvl = int'($urandom_range(4)) - 2;
      if ($urandom_range(9) == 0) segG = 8'($urandom);
      else segG = legal[$urandom_range(8)];
      for (int n = 0; n < segLen; n++) begin
        segV = segLvl * dc / 2 + int'($urandom_range(dc / 3)) - dc / 6;
        cycle(dc, segV, segG, $urandom_range(29) == 0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule